// File: doc/BRIEF.md
# One-Sided Synchronous-Interface Port

This port links a block whose clock runs at a fixed rate to a module whose local clock can be paused. Only the local module can stop to synchronize, so all of the synchronization work happens on that side. To start a transfer, the external side raises an enable. A half-period gate turns that enable into a request. When the local module has also enabled the port, a small sequencer asks the local clock generator to pause and then grants the exchange. A second half-period gate passes the grant back to the external side as a done flag.

Both gates are transparent only during the first half of the external clock period. The external clock level itself serves as the phase input. Because every handshake edge seen by the slow side lands in that half, the slow side can sample done and update enable at its own edge without pausing. The port holds no data. The external output registers are stable before enable rises, and the same external edge that samples done also captures the data. The external period must be several local periods long; the default ratio of the checker is 16.

Top module: `sync_side_port`

## Requirements
- R1: While rst_ni is low, and until the first transfer after it, pause_o, ack_o and done_o are 0, and both gates hold 0.
- R2: With the request gate holding 1 and loc_en_i high, pause_o rises one local cycle later. When ext_en_i and loc_en_i rise together at the start of an external period, pause_o is high after the second local edge and ack_o is still 0.
- R3: ack_o rises exactly one local cycle after pause_o rises.
- R4: done_o copies ack_o only on local edges where ext_phase_i is 1, the first half of the external period, and holds otherwise. In the basic case done_o is 1 after the fourth local edge.
- R5: A change of ext_en_i reaches the request only on an edge where ext_phase_i is 1. If enable falls in the second half, the request stays high until the next first half.
- R6: pause_o and ack_o stay high until the request falls, and both drop one local cycle after it does.
- R7: While loc_en_i is 0, an asserted enable causes no pause, grant or done.
- R8: Once pause_o is high, dropping loc_en_i does not abort the sequence: the grant and done still follow.
- R9: When the grant can complete inside the first half (loc_en_i high by cycle 5 of a 16-cycle period, counted from 0), done is seen at the next external edge. Otherwise it is deferred by exactly one external period. With both enables high, done_o rises within CLK_RATIO local cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock, modelled as free running |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_en_i | input | 1 | Transfer enable from the external side |
| ext_phase_i | input | 1 | High during the first half of the external period |
| loc_en_i | input | 1 | Port enable from the local module |
| pause_o | output | 1 | Request to pause the local clock |
| ack_o | output | 1 | Grant to the local module: data may be exchanged |
| done_o | output | 1 | Half-period-gated grant toward the external side |

## Verification
The main transfer is driven with the local enable arriving at different offsets inside the external period. Offsets 0, 4 and 5 must finish in one external period. Offset 6 is the first that misses the first half and slips by a whole period. Offsets 8, 20 and 22 show that a late grant is held back to the next first half and not delivered mid-period. Directed cases cover three further patterns, each telling a different fault apart: a withheld local enable separates a correct idle port from one that pauses on the external request alone; an enable dropped in the second half separates a gated request release from an ungated one; a local enable withdrawn after the pause separates a committed sequence from one that aborts.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_HOLD  = 2'd1,
    SEQ_GRANT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ssp_half_gate.sv
// Per-bit hold element: transparent while phase_i is high.
module ssp_half_gate #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         phase_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q_o[b] <= 1'b0;
      else if (phase_i) q_o[b] <= d_i[b];
    end
  end
endmodule

// File: rtl/ssp_seq.sv
module ssp_seq
  import ssp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic loc_en_i,
  output logic pause_o,
  output logic ack_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (req_i && loc_en_i) state_d = SEQ_HOLD;
      SEQ_HOLD:  state_d = req_i ? SEQ_GRANT : SEQ_IDLE;
      SEQ_GRANT: if (!req_i) state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assign pause_o = (state_q != SEQ_IDLE);
  assign ack_o   = (state_q == SEQ_GRANT);
endmodule

// File: rtl/sync_side_port.sv
module sync_side_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_en_i,
  input  logic ext_phase_i,
  input  logic loc_en_i,
  output logic pause_o,
  output logic ack_o,
  output logic done_o
);
  logic req_q;
  logic ack_int;

  ssp_half_gate #(.W(1)) i_req_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (ext_phase_i),
    .d_i     (ext_en_i),
    .q_o     (req_q)
  );

  ssp_seq i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_q),
    .loc_en_i (loc_en_i),
    .pause_o  (pause_o),
    .ack_o    (ack_int)
  );

  ssp_half_gate #(.W(1)) i_done_gate (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .phase_i (ext_phase_i),
    .d_i     (ack_int),
    .q_o     (done_o)
  );

  assign ack_o = ack_int;
endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
  parameter int CLK_RATIO = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ext_en_i,
  input logic ext_phase_i,
  input logic loc_en_i,
  input logic pause_o,
  input logic ack_o,
  input logic done_o,
  input logic req_q
);
  localparam int CW = $clog2(CLK_RATIO) + 1;
  logic [CW-1:0] wait_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                     wait_q <= '0;
    else if (!(ext_en_i && loc_en_i) || done_o)      wait_q <= '0;
    else if (wait_q != CW'(CLK_RATIO))               wait_q <= wait_q + 1'b1;
  end

  // R3
  grant_follows_pause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pause_o && !ack_o && req_q) |=> ack_o);

  // R4
  done_first_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(done_o) |-> $past(ext_phase_i));

  // R5
  req_first_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(req_q) |-> $past(ext_phase_i));

  // R6
  pause_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && req_q) |=> pause_o);

  // R7
  no_pause_unenabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pause_o && !loc_en_i) |=> !pause_o);

  // R9
  sync_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_q < CW'(CLK_RATIO));
endmodule

bind sync_side_port ssp_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ext_en_i    (ext_en_i),
  .ext_phase_i (ext_phase_i),
  .loc_en_i    (loc_en_i),
  .pause_o     (pause_o),
  .ack_o       (ack_o),
  .done_o      (done_o),
  .req_q       (req_q)
);

// File: tb/test_sync_side_port.sv
`timescale 1ns/1ps
module test_sync_side_port;
  localparam int R    = 16;
  localparam int HALF = R / 2;
  localparam int NV   = 7;
  localparam int VEC_OFF [NV] = '{0, 4, 5, 6, 8, 20, 22};
  localparam int VEC_EXP [NV] = '{1, 1, 1, 2, 2, 2, 3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_en = 1'b0, ext_phase = 1'b0, loc_en = 1'b0;
  logic pause, ack, done;
  int cnt = R - 1;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  sync_side_port i_sync_side_port (
    .clk_i(clk), .rst_ni(rst_n), .ext_en_i(ext_en), .ext_phase_i(ext_phase),
    .loc_en_i(loc_en), .pause_o(pause), .ack_o(ack), .done_o(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cnt = (cnt + 1) % R;
    ext_phase = (cnt < HALF);
  endtask

  task automatic to_period_start();
    tick();
    while (cnt != 0) tick();
  endtask

  task automatic settle();
    for (int i = 0; i < 3 * R && (pause || done); i++) tick();
  endtask

  initial begin
    int guard = 0;
    while (guard < 100000) begin
      @(posedge clk);
      guard++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", guard, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int periods;
    bit seen;
    repeat (3) tick();
    // R1 reset state
    check({pause, ack, done} == 3'b000, "R1 in reset", {pause, ack, done}, 0);
    rst_n = 1'b1;
    to_period_start();
    check({pause, ack, done} == 3'b000, "R1 after reset", {pause, ack, done}, 0);

    // Vector table: loc_en offset vs external periods until done
    for (int v = 0; v < NV; v++) begin
      to_period_start();
      ext_en = 1'b1;
      loc_en = (VEC_OFF[v] == 0);
      periods = 0; seen = 0;
      for (int t = 1; t < 6 * R && !seen; t++) begin
        tick();
        if (t == VEC_OFF[v]) loc_en = 1'b1;
        if (cnt == 0) begin
          periods++;
          if (done) begin seen = 1; ext_en = 1'b0; end
        end
      end
      // R9 sync latency
      check(seen && periods == VEC_EXP[v], "R9 periods to done", periods, VEC_EXP[v]);
      settle();
      loc_en = 1'b0;
      check(!done && !pause, "R6 return to idle", {pause, done}, 0);
    end

    // Detailed timing, both enables at period start
    to_period_start();
    ext_en = 1'b1; loc_en = 1'b1;
    tick(); tick();
    check(pause && !ack, "R2 pause before grant", {pause, ack}, 2);
    check(!done, "R4 done not yet", done, 0);
    tick();
    check(ack, "R3 grant one cycle after pause", ack, 1);
    tick();
    check(done, "R4 done after fourth edge", done, 1);
    // Drop enable in the second half
    while (cnt != HALF) tick();
    ext_en = 1'b0;
    while (cnt != 0) begin
      tick();
      if (cnt != 0 && !pause) check(0, "R5 release gated to first half", pause, 1);
    end
    check(pause && ack, "R5 still paused at period edge", {pause, ack}, 3);
    tick();
    check(pause, "R6 pause one cycle after request fall", pause, 1);
    tick();
    check(!pause && !ack, "R6 pause and grant dropped", {pause, ack}, 0);
    check(done, "R4 done held until gate passes", done, 1);
    tick();
    check(!done, "R4 done falls in first half", done, 0);
    loc_en = 1'b0;
    settle();

    // R7 no local enable
    to_period_start();
    ext_en = 1'b1; loc_en = 1'b0;
    seen = 0;
    for (int t = 0; t < 2 * R; t++) begin
      tick();
      if (pause || ack || done) seen = 1;
    end
    check(!seen, "R7 no pause without local enable", seen, 0);
    ext_en = 1'b0;
    to_period_start();

    // R8 local enable dropped after pause
    to_period_start();
    ext_en = 1'b1; loc_en = 1'b1;
    tick(); tick();
    check(pause, "R8 pause raised", pause, 1);
    loc_en = 1'b0;
    tick();
    check(ack, "R8 grant despite local drop", ack, 1);
    tick();
    check(done, "R8 done despite local drop", done, 1);
    to_period_start();
    ext_en = 1'b0;
    settle();
    check(!pause && !done, "R8 idle after completion", {pause, done}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule